// File: doc/BRIEF.md
# Masked Multi-Line Event Interrupt Controller

This block gathers the event flags of an Ethernet MAC into a 32-bit event word and gates them with a 32-bit enable mask. Thirteen named events occupy fixed positions in the upper part of the event word. Each event drives its own interrupt line, so thirteen separate lines leave the block. Producers inside the MAC (transmit, receive, management and control logic) raise events with single-cycle pulses. Software reads the event and mask words through a simple register port. It acknowledges events by writing ones to the event word and writes a new mask when it wants a different set of lines enabled.

An event counts as active while both its event bit and its mask bit are 1. Every interrupt line is a flop that copies its active condition. A line therefore rises one cycle after the condition first holds, falls one cycle after it stops holding, and otherwise keeps its value. Two producer strobes get special treatment. A write to the PHY management frame register raises the management event. A write to the transmit control register with its stop-request bit set raises the graceful-stop-complete event at once.

Top module: `mac_evt_irq`

## Requirements
- R1: The events sit at these bit positions of the event word: heartbeat 31, babbling receive 30, babbling transmit 29, graceful stop complete 28, transmit frame 27, transmit buffer 26, receive frame 25, receive buffer 24, management 23, bus error 22, late collision 21, retry limit 20, underrun 19. `reg_sel` = 0 reads or writes the event word, and `reg_sel` = 1 reads or writes the mask word. `reg_rdata` shows the selected word in the same cycle.
- R2: A pulse on `evt_set[i]` sets the event bit of line i in the next cycle. Line indices are listed in R5.
- R3: A write of the event word clears every event bit that the written data holds as 1. Bits written as 0 keep their value.
- R4: A write of the mask word replaces all 32 mask bits, and the new value reads back from the next cycle on.
- R5: Line indices 0 to 12 of `irq_line` carry, in order: transmit frame, transmit buffer, underrun, retry limit, receive frame, receive buffer, management, late collision, heartbeat, graceful stop, bus error, babbling transmit, babbling receive.
- R6: Each line equals, one cycle later, the AND of its event bit and its mask bit. A line rises only one cycle after that condition first holds, and it never changes while the condition stays constant.
- R7: A pulse on `mgmt_frame_wr` sets the management event (bit 23).
- R8: A pulse on `tx_ctrl_wr` with `tx_ctrl_stop` = 1 sets the graceful stop event (bit 28). With `tx_ctrl_stop` = 0 the pulse has no effect.
- R9: When a set pulse and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R10: Synchronous reset clears the event word, the mask word and all lines.
- R11: Event bits 18 to 0 always read as 0. Clearing them has no effect on the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 event word, 1 mask word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| evt_set | input | 13 | Event set pulses, one per line index |
| mgmt_frame_wr | input | 1 | Management frame register write strobe |
| tx_ctrl_wr | input | 1 | Transmit control register write strobe |
| tx_ctrl_stop | input | 1 | Stop-request bit of that write |
| irq_line | output | 13 | Interrupt lines |

## Verification
A producer's set pulse and a software write-one-to-clear can land on the same event bit in the same cycle. The bench provokes this with directed cycles that pulse a line while clearing all bits, and with random cycles that overlap pulses and clear writes. The outcome is judged against a bench model in which set has priority, by reading back the event word and by watching the matching line rise one cycle later.

// File: rtl/mac_evt_pkg.sv
package mac_evt_pkg;

    localparam int EVT_W     = 32;
    localparam int NUM_LINES = 13;
    localparam int LN_MII    = 6;
    localparam int LN_GRA    = 9;
    localparam int LOW_MAPPED = 19;

    typedef enum logic {
        SEL_EVENT = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [EVT_W-1:0] data;
    } reg_req_t;

    // Event-word bit position served by each interrupt line.
    function automatic int line_bit(input int ln);
        case (ln)
            0:       return 27;
            1:       return 26;
            2:       return 19;
            3:       return 20;
            4:       return 25;
            5:       return 24;
            6:       return 23;
            7:       return 21;
            8:       return 31;
            9:       return 28;
            10:      return 22;
            11:      return 29;
            default: return 30;
        endcase
    endfunction

endpackage

// File: rtl/mac_evt_store.sv
module mac_evt_store
    import mac_evt_pkg::*;
#(
    parameter int N_LN  = NUM_LINES,
    parameter int WORD_W = EVT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] clr_data,
    input  logic [N_LN-1:0]   set_lines,
    output logic [N_LN-1:0]   evt_q,
    output logic [WORD_W-1:0] evt_word
);

    for (genvar i = 0; i < N_LN; i++) begin : g_evt
        localparam int BP = line_bit(i);
        logic clr_hit;

        assign clr_hit = clr_en & clr_data[BP];

        always_ff @(posedge clk) begin
            if (rst) begin
                evt_q[i] <= 1'b0;
            end else begin
                evt_q[i] <= set_lines[i] | (evt_q[i] & ~clr_hit);
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_lines[i] |=> evt_q[i]);                                   // R9
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_data[BP] && !set_lines[i]) |=> !evt_q[i]);     // R3
        AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (evt_q[i] && !(clr_en && clr_data[BP])) |=> evt_q[i]);        // R3
    end

    always_comb begin
        evt_word = '0;
        for (int k = 0; k < N_LN; k++) begin
            evt_word[line_bit(k)] = evt_q[k];
        end
    end

    AST_EVT_RESET: assert property (@(posedge clk)
        rst |=> (evt_q == '0));                                           // R10

endmodule

// File: rtl/mac_evt_mask.sv
module mac_evt_mask
    import mac_evt_pkg::*;
#(
    parameter int WORD_W = EVT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= load_data;
        end
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (mask_q == $past(load_data)));                           // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mask_q));                                       // R4
    AST_MASK_RESET: assert property (@(posedge clk)
        rst |=> (mask_q == '0));                                          // R10

endmodule

// File: rtl/mac_evt_lines.sv
module mac_evt_lines
    import mac_evt_pkg::*;
#(
    parameter int N_LN   = NUM_LINES,
    parameter int WORD_W = EVT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] evt_word,
    input  logic [WORD_W-1:0] mask_word,
    output logic [N_LN-1:0]   irq_q
);

    logic [N_LN-1:0] active;

    for (genvar i = 0; i < N_LN; i++) begin : g_line
        localparam int BP = line_bit(i);
        assign active[i] = evt_word[BP] & mask_word[BP];

        AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (irq_q[i] == $past(evt_word[BP] & mask_word[BP])));  // R6
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= active;
        end
    end

    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $stable(active) |=> $stable(irq_q));                              // R6
    AST_LINE_RESET: assert property (@(posedge clk)
        rst |=> (irq_q == '0));                                           // R10

endmodule

// File: rtl/mac_evt_irq.sv
module mac_evt_irq
    import mac_evt_pkg::*;
#(
    parameter int N_LN   = NUM_LINES,
    parameter int WORD_W = EVT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [N_LN-1:0]   evt_set,
    input  logic              mgmt_frame_wr,
    input  logic              tx_ctrl_wr,
    input  logic              tx_ctrl_stop,
    output logic [N_LN-1:0]   irq_line
);

    reg_req_t          req;
    logic [N_LN-1:0]   set_lines;
    logic [N_LN-1:0]   evt_q;
    logic [WORD_W-1:0] evt_word;
    logic [WORD_W-1:0] mask_word;

    always_comb begin
        req.wr   = reg_wr;
        req.sel  = reg_sel_e'(reg_sel);
        req.data = reg_wdata;
    end

    always_comb begin
        set_lines         = evt_set;
        set_lines[LN_MII] = evt_set[LN_MII] | mgmt_frame_wr;
        set_lines[LN_GRA] = evt_set[LN_GRA] | (tx_ctrl_wr & tx_ctrl_stop);
    end

    mac_evt_store #(.N_LN(N_LN), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr_en    (req.wr && req.sel == SEL_EVENT),
        .clr_data  (req.data),
        .set_lines (set_lines),
        .evt_q     (evt_q),
        .evt_word  (evt_word)
    );

    mac_evt_mask #(.WORD_W(WORD_W)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .load      (req.wr && req.sel == SEL_MASK),
        .load_data (req.data),
        .mask_q    (mask_word)
    );

    mac_evt_lines #(.N_LN(N_LN), .WORD_W(WORD_W)) u_lines (
        .clk       (clk),
        .rst       (rst),
        .evt_word  (evt_word),
        .mask_word (mask_word),
        .irq_q     (irq_line)
    );

    assign reg_rdata = (req.sel == SEL_MASK) ? mask_word : evt_word;

    AST_MII_STROBE: assert property (@(posedge clk) disable iff (rst)
        mgmt_frame_wr |=> evt_word[23]);                                  // R7
    AST_STOP_STROBE: assert property (@(posedge clk) disable iff (rst)
        (tx_ctrl_wr && tx_ctrl_stop) |=> evt_word[28]);                   // R8
    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (rst)
        evt_set[0] |=> evt_word[27]);                                     // R2
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (evt_word[LOW_MAPPED-1:0] == '0));                                // R11

endmodule

// File: tb/mac_evt_irq_bench.sv
module mac_evt_irq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [12:0] evt_set = '0;
    logic        mgmt_frame_wr = 1'b0;
    logic        tx_ctrl_wr = 1'b0;
    logic        tx_ctrl_stop = 1'b0;
    logic [12:0] irq_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_evt  = '0;
    logic [31:0] m_mask = '0;
    logic [12:0] m_lines = '0;

    always #10 clk = ~clk;

    mac_evt_irq u_mac_evt_irq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
        .mgmt_frame_wr(mgmt_frame_wr), .tx_ctrl_wr(tx_ctrl_wr),
        .tx_ctrl_stop(tx_ctrl_stop), .irq_line(irq_line)
    );

    function automatic int pos_of(input int ln);
        int tbl[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
        return tbl[ln];
    endfunction

    function automatic logic [12:0] lines_of(input logic [31:0] ev, input logic [31:0] mk);
        logic [12:0] r;
        for (int i = 0; i < 13; i++) r[i] = ev[pos_of(i)] & mk[pos_of(i)];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        reg_sel = 1'b0;
        #1 chk({tag, " event"}, reg_rdata, m_evt);
        reg_sel = 1'b1;
        #1 chk({tag, " mask"}, reg_rdata, m_mask);
        chk({tag, " lines"}, {19'd0, irq_line}, {19'd0, m_lines});
    endtask

    // Called at a falling edge; applies one cycle of stimulus and checks.
    task automatic step(input string tag, input logic r, input logic wr, input logic sel,
                        input logic [31:0] wd, input logic [12:0] hs,
                        input logic mg, input logic tw, input logic ts);
        logic [31:0] setw;
        rst = r; reg_wr = wr; reg_sel = sel; reg_wdata = wd; evt_set = hs;
        mgmt_frame_wr = mg; tx_ctrl_wr = tw; tx_ctrl_stop = ts;
        @(posedge clk);
        if (r) begin
            m_evt = '0; m_mask = '0; m_lines = '0;
        end else begin
            m_lines = lines_of(m_evt, m_mask);
            setw = '0;
            for (int i = 0; i < 13; i++) if (hs[i]) setw[pos_of(i)] = 1'b1;
            if (mg) setw[23] = 1'b1;
            if (tw && ts) setw[28] = 1'b1;
            if (wr && !sel) m_evt = m_evt & ~wd;
            m_evt = m_evt | setw;
            if (wr && sel) m_mask = wd;
        end
        @(negedge clk);
        rst = 1'b0; reg_wr = 1'b0; evt_set = '0; mgmt_frame_wr = 1'b0;
        tx_ctrl_wr = 1'b0; tx_ctrl_stop = 1'b0;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, 1'b0, 32'h0, 13'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        step("R10 reset", 1'b1, 1'b0, 1'b0, 32'h0, 13'h0, 1'b0, 1'b0, 1'b0);
        step("R10 reset", 1'b1, 1'b0, 1'b0, 32'h0, 13'h0, 1'b0, 1'b0, 1'b0);
        chk("R10 lines after reset", {19'd0, irq_line}, 32'h0);

        step("R4 mask all", 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 13'h0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 13; i++) begin
            step("R2 pulse", 1'b0, 1'b0, 1'b0, 32'h0, 13'h1 << i, 1'b0, 1'b0, 1'b0);
            chk("R1 bit position", m_evt, 32'h1 << pos_of(i));
            chk("R6 line not yet high", {19'd0, irq_line}, 32'h0);
            idle("R5 line map");
            chk("R5 line index", {19'd0, irq_line}, 32'h1 << i);
            step("R3 w1c", 1'b0, 1'b1, 1'b0, 32'h1 << pos_of(i), 13'h0, 1'b0, 1'b0, 1'b0);
            idle("R6 line falls");
        end

        step("R2 all pulse", 1'b0, 1'b0, 1'b0, 32'h0, 13'h1FFF, 1'b0, 1'b0, 1'b0);
        step("R3 partial clear", 1'b0, 1'b1, 1'b0, 32'h0F0F_0000, 13'h0, 1'b0, 1'b0, 1'b0);
        step("R11 low clear", 1'b0, 1'b1, 1'b0, 32'h0007_FFFF, 13'h0, 1'b0, 1'b0, 1'b0);
        step("R9 set vs clear", 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 13'h0011, 1'b0, 1'b0, 1'b0);
        chk("R9 survived", m_evt, 32'h0A00_0000);
        step("R3 clear all", 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 13'h0, 1'b0, 1'b0, 1'b0);

        step("R7 mgmt", 1'b0, 1'b0, 1'b0, 32'h0, 13'h0, 1'b1, 1'b0, 1'b0);
        chk("R7 mii bit", m_evt, 32'h0080_0000);
        step("R8 no stop", 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 13'h0, 1'b0, 1'b1, 1'b0);
        chk("R8 nothing set", m_evt, 32'h0);
        step("R8 stop", 1'b0, 1'b0, 1'b0, 32'h0, 13'h0, 1'b0, 1'b1, 1'b1);
        chk("R8 gra bit", m_evt, 32'h1000_0000);
        step("R9 stop vs clear", 1'b0, 1'b1, 1'b0, 32'h1000_0000, 13'h0, 1'b0, 1'b1, 1'b1);

        step("R6 mask off", 1'b0, 1'b1, 1'b1, 32'h0, 13'h0, 1'b0, 1'b0, 1'b0);
        idle("R6 masked low");
        step("R6 mask on", 1'b0, 1'b1, 1'b1, 32'h1000_0000, 13'h0, 1'b0, 1'b0, 1'b0);
        chk("R6 one cycle after", {19'd0, irq_line}, 32'h0);
        idle("R6 rises");
        idle("R6 holds");

        for (int c = 0; c < 600; c++) begin
            logic wr = ($urandom % 3) == 0;
            logic sel = $urandom % 2;
            logic [31:0] wd = $urandom;
            logic [12:0] hs = 13'($urandom & $urandom & $urandom);
            step("R2 random mix", 1'b0, wr, sel, wd, hs,
                 ($urandom % 8) == 0, ($urandom % 6) == 0, $urandom % 2);
        end

        step("R10 mid reset", 1'b1, 1'b0, 1'b0, 32'h0, 13'h1FFF, 1'b1, 1'b0, 1'b0);
        idle("R10 after reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule